// File: doc/BRIEF.md
# Writeback and Branch Redirect Unit

This is the last stage of an in-order pipeline. Each cycle it can retire one instruction, and it never asks the upstream stage to wait. Decode pushes the destination index of every register-writing instruction into a small in-order queue of pending destinations. When a register-type or immediate-type instruction retires, the unit pops the oldest pending index and writes the instruction's result operand into a 32-entry register file. Store-class instructions still consume their queue entry but leave the register file unchanged. An index outside the register range is also consumed without a write.

A jump-type instruction carries its resolved target in the result operand. The unit compares this target with the PC reported by fetch. If they are equal, nothing happens. If they differ, the jump counts as taken:
- a jump-and-link writes the fetch PC plus one into register 1;
- the pending-destination queue is emptied;
- one cycle later, a one-cycle squash pulse goes out to the earlier stages together with the new PC.

Branch logic reads condition flags as single bits of register 3. A combinational read port gives access to the register file.

Top module: `wb_redirect_unit`

## Requirements
- R1: After reset, every register reads 0, the queue is empty and not full, `squash` is 0 and `redirectPc` is 0.
- R2: A retire with `retKind` 1 (register) or 2 (immediate) and a non-empty queue pops the oldest index and writes `retOperand` to that register. The new value is readable on `rdData` in the cycle after the retire edge. Register 0 is written like any other register.
- R3: Indices leave the queue in the order they were pushed. A push and a pop may happen in the same cycle.
- R4: A register or immediate retire with `retOp` 1 (store) or 2 (vector store) pops its entry but writes no register.
- R5: A popped index of 32 or more is consumed and produces no write to any register.
- R6: A register or immediate retire with an empty queue writes nothing. A retire with `retKind` 0 (other) has no effect on the registers or the queue.
- R7: A retire with `retKind` 3 (jump) whose `retOperand` equals `fetchPc` writes nothing, leaves the queue untouched and raises no squash, even with `retOp` 3.
- R8: A jump retire whose `retOperand` differs from `fetchPc` empties the queue at the retire edge. In the following cycle `squash` is 1 for exactly one cycle (unless a further taken jump follows) and `redirectPc` holds the target.
- R9: A taken jump with `retOp` 3 (jump-and-link) writes `fetchPc + 1` into register 1.
- R10: A push in the same cycle as a taken jump is discarded.
- R11: `condFlag` equals bit `condSel` of register 3, combinationally.
- R12: The queue holds 8 entries. `destFull` is 1 when it holds 8. A push while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Decode enqueues a pending destination |
| pushIdx | input | 6 | Destination index to enqueue |
| destFull | output | 1 | Queue holds 8 entries |
| destEmpty | output | 1 | Queue holds no entries |
| retValid | input | 1 | An instruction retires this cycle |
| retKind | input | 2 | 0 other, 1 register, 2 immediate, 3 jump |
| retOp | input | 3 | 0 plain, 1 store, 2 vector store, 3 jump-and-link, 4 jump |
| retOperand | input | 32 | Result value, or jump target |
| fetchPc | input | 32 | Current PC from fetch |
| squash | output | 1 | One-cycle flush of earlier stages |
| redirectPc | output | 32 | New PC after a taken jump |
| rdAddr | input | 5 | Register file read index |
| rdData | output | 32 | Register file read data |
| condSel | input | 5 | Condition flag select |
| condFlag | output | 1 | Selected bit of register 3 |

## Verification
The bench aims at ordering and discard corner cases. It checks that queue entries drain oldest first, so a LIFO or an off-by-one pointer would put values in the wrong registers. It checks that stores and out-of-range indices still consume their entry: a design that skipped the pop would shift every later write to the wrong register. It also covers:
- a jump whose target equals the PC, which must not squash;
- a push in the same cycle as a taken jump, which a careless flush would leave stranded in the queue;
- a full queue, where an overwrite would corrupt the oldest entry;
- the link value, where an off-by-one would show up in register 1.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int NUM_REGS = 32;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int LINK_REG = 1;
  localparam int FLAG_REG = 3;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_REG   = 2'd1,
    KIND_IMM   = 2'd2,
    KIND_JUMP  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    OP_PLAIN  = 3'd0,
    OP_STORE  = 3'd1,
    OP_VSTORE = 3'd2,
    OP_LINK   = 3'd3,
    OP_JUMP   = 3'd4
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              popDest;
    logic              wrEn;
    logic [REG_AW-1:0] wrIdx;
    logic              linkWr;
    logic              flush;
  } wbr_strobe_t;
endpackage

// File: rtl/wbr_dest_fifo.sv
module wbr_dest_fifo #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushValid,
  input  logic [IDX_W-1:0] pushIdx,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] frontIdx,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign frontIdx = slots[rdPtr];
  assign doPush   = pushValid && !full && !flush;
  assign doPop    = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushIdx;
  end

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && pushValid && !pop && !flush |=> full && frontIdx == $past(frontIdx));
endmodule

// File: rtl/wbr_ctrl.sv
module wbr_ctrl
  import wbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retValid,
  input  logic [1:0]        retKind,
  input  logic [2:0]        retOp,
  input  logic [DATA_W-1:0] retOperand,
  input  logic [DATA_W-1:0] fetchPc,
  input  logic [IDX_W-1:0]  frontIdx,
  input  logic              destEmpty,
  output wbr_strobe_t       strobe
);
  logic isRegImm, isStoreOp, idxInRange, jumpTaken;

  assign isRegImm   = (retKind == KIND_REG) || (retKind == KIND_IMM);
  assign isStoreOp  = (retOp == OP_STORE) || (retOp == OP_VSTORE);
  assign idxInRange = (frontIdx < IDX_W'(NUM_REGS));
  assign jumpTaken  = retValid && (retKind == KIND_JUMP) && (retOperand != fetchPc);

  always_comb begin
    strobe         = '0;
    strobe.popDest = retValid && isRegImm && !destEmpty;
    strobe.wrEn    = strobe.popDest && idxInRange && !isStoreOp;
    strobe.wrIdx   = frontIdx[REG_AW-1:0];
    strobe.flush   = jumpTaken;
    strobe.linkWr  = jumpTaken && (retOp == OP_LINK);
  end

  // R4
  store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retValid && isRegImm && isStoreOp |-> !strobe.wrEn);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.popDest && frontIdx >= IDX_W'(NUM_REGS) |-> !strobe.wrEn);

  // R7
  same_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retValid && retKind == KIND_JUMP && retOperand == fetchPc |-> !strobe.flush && !strobe.linkWr);
endmodule

// File: rtl/wbr_datapath.sv
module wbr_datapath
  import wbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wbr_strobe_t       strobe,
  input  logic [DATA_W-1:0] retOperand,
  input  logic [DATA_W-1:0] fetchPc,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [SEL_W-1:0]  condSel,
  output logic              condFlag,
  output logic              squash,
  output logic [DATA_W-1:0] redirectPc
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] flagWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (strobe.wrEn)   regs[strobe.wrIdx] <= retOperand;
      if (strobe.linkWr) regs[LINK_REG] <= fetchPc + DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      squash     <= 1'b0;
      redirectPc <= '0;
    end else begin
      squash <= strobe.flush;
      if (strobe.flush) redirectPc <= retOperand;
    end
  end

  assign rdData   = regs[rdAddr];
  assign flagWord = regs[FLAG_REG];
  assign condFlag = flagWord[condSel];

  // R8
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> squash && redirectPc == $past(retOperand));

  // R9
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.linkWr |=> regs[LINK_REG] == $past(fetchPc) + DATA_W'(1));
endmodule

// File: rtl/wb_redirect_unit.sv
module wb_redirect_unit
  import wbr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 6,
  parameter int FIFO_DEPTH = 8,
  parameter int SEL_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [IDX_W-1:0]  pushIdx,
  output logic              destFull,
  output logic              destEmpty,
  input  logic              retValid,
  input  logic [1:0]        retKind,
  input  logic [2:0]        retOp,
  input  logic [DATA_W-1:0] retOperand,
  input  logic [DATA_W-1:0] fetchPc,
  output logic              squash,
  output logic [DATA_W-1:0] redirectPc,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [SEL_W-1:0]  condSel,
  output logic              condFlag
);
  wbr_strobe_t      strobe;
  logic [IDX_W-1:0] frontIdx;

  wbr_dest_fifo #(.DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .pushValid(pushValid), .pushIdx(pushIdx),
    .pop(strobe.popDest), .flush(strobe.flush),
    .frontIdx(frontIdx), .full(destFull), .empty(destEmpty)
  );

  wbr_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .retValid(retValid), .retKind(retKind), .retOp(retOp),
    .retOperand(retOperand), .fetchPc(fetchPc),
    .frontIdx(frontIdx), .destEmpty(destEmpty), .strobe(strobe)
  );

  wbr_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .retOperand(retOperand), .fetchPc(fetchPc),
    .rdAddr(rdAddr), .rdData(rdData),
    .condSel(condSel), .condFlag(condFlag),
    .squash(squash), .redirectPc(redirectPc)
  );
endmodule

// File: tb/wb_redirect_unit_test.sv
module wb_redirect_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pushValid = 1'b0;
  logic [5:0]  pushIdx = '0;
  logic        destFull, destEmpty;
  logic        retValid = 1'b0;
  logic [1:0]  retKind = '0;
  logic [2:0]  retOp = '0;
  logic [31:0] retOperand = '0;
  logic [31:0] fetchPc = '0;
  logic        squash;
  logic [31:0] redirectPc;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [4:0]  condSel = '0;
  logic        condFlag;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  wb_redirect_unit uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkRegs(string req);
    for (int i = 0; i < 32; i++) begin
      rdAddr = 5'(i);
      #1;
      check(req, rdData, model[i]);
    end
  endtask

  // one cycle of stimulus, inputs cleared at the next falling edge
  task automatic cycle(logic pv, logic [5:0] pi, logic rv, logic [1:0] k,
                       logic [2:0] op, logic [31:0] val, logic [31:0] pc);
    pushValid = pv; pushIdx = pi; retValid = rv; retKind = k;
    retOp = op; retOperand = val; fetchPc = pc;
    @(negedge clk);
    pushValid = 1'b0; retValid = 1'b0;
  endtask

  task automatic push(logic [5:0] idx);
    cycle(1'b1, idx, 1'b0, 2'd0, 3'd0, 32'h0, 32'h0);
  endtask

  task automatic retire(logic [1:0] k, logic [2:0] op, logic [31:0] val, logic [31:0] pc);
    cycle(1'b0, 6'd0, 1'b1, k, op, val, pc);
  endtask

  task automatic t_reset();
    check("R1 empty", destEmpty, 1);
    check("R1 full", destFull, 0);
    check("R1 squash", squash, 0);
    check("R1 redirectPc", redirectPc, 0);
    checkRegs("R1 regs");
  endtask

  task automatic t_basic();
    push(6'd5); push(6'd7); push(6'd0);
    retire(2'd1, 3'd0, 32'h11, 32'h0);
    rdAddr = 5'd5; #1; check("R2 first write", rdData, 32'h11);
    retire(2'd2, 3'd0, 32'h22, 32'h0);
    retire(2'd1, 3'd0, 32'h33, 32'h0);
    model[5] = 32'h11; model[7] = 32'h22; model[0] = 32'h33;
    checkRegs("R3 order");
    check("R2 drained", destEmpty, 1);
    // push and pop together
    push(6'd9);
    cycle(1'b1, 6'd10, 1'b1, 2'd1, 3'd0, 32'h44, 32'h0);
    retire(2'd1, 3'd0, 32'h45, 32'h0);
    model[9] = 32'h44; model[10] = 32'h45;
    checkRegs("R3 push with pop");
    check("R3 drained", destEmpty, 1);
  endtask

  task automatic t_store();
    push(6'd12); push(6'd13); push(6'd14);
    retire(2'd1, 3'd1, 32'hAA, 32'h0);
    retire(2'd2, 3'd2, 32'hBB, 32'h0);
    retire(2'd1, 3'd0, 32'hCC, 32'h0);
    model[14] = 32'hCC;
    checkRegs("R4 store no write");
    check("R4 popped", destEmpty, 1);
  endtask

  task automatic t_bigidx();
    push(6'd40); push(6'd4);
    retire(2'd1, 3'd0, 32'h55, 32'h0);
    retire(2'd1, 3'd0, 32'h66, 32'h0);
    model[4] = 32'h66;
    checkRegs("R5 out of range");
    check("R5 popped", destEmpty, 1);
  endtask

  task automatic t_empty();
    retire(2'd1, 3'd0, 32'h77, 32'h0);
    push(6'd15);
    retire(2'd0, 3'd0, 32'h78, 32'h0);
    checkRegs("R6 no write");
    check("R6 other keeps entry", destEmpty, 0);
    retire(2'd1, 3'd0, 32'h79, 32'h0);
    model[15] = 32'h79;
    checkRegs("R6 entry intact");
  endtask

  task automatic t_nottaken();
    push(6'd6);
    retire(2'd3, 3'd4, 32'h40, 32'h40);
    check("R7 no squash", squash, 0);
    retire(2'd3, 3'd3, 32'h80, 32'h80);
    check("R7 no squash link", squash, 0);
    check("R7 queue kept", destEmpty, 0);
    checkRegs("R7 no link write");
    retire(2'd1, 3'd0, 32'h88, 32'h0);
    model[6] = 32'h88;
    checkRegs("R7 entry survives");
  endtask

  task automatic t_taken();
    push(6'd11); push(6'd17);
    retire(2'd3, 3'd3, 32'h100, 32'h20);
    model[1] = 32'h21;
    check("R8 squash high", squash, 1);
    check("R8 redirectPc", redirectPc, 32'h100);
    check("R8 flushed", destEmpty, 1);
    checkRegs("R9 link value");
    @(negedge clk);
    check("R8 squash pulse", squash, 0);
    retire(2'd1, 3'd0, 32'h99, 32'h0);
    checkRegs("R8 no stale write");
    // plain jump: no link
    retire(2'd3, 3'd4, 32'h200, 32'h30);
    check("R8 plain redirect", redirectPc, 32'h200);
    checkRegs("R9 plain jump no link");
  endtask

  task automatic t_flushpush();
    cycle(1'b1, 6'd13, 1'b1, 2'd3, 3'd4, 32'h300, 32'h50);
    check("R10 push dropped", destEmpty, 1);
    @(negedge clk);
    retire(2'd1, 3'd0, 32'h5A, 32'h0);
    checkRegs("R10 no write");
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) push(6'(16 + i));
    check("R12 full", destFull, 1);
    push(6'd30);
    check("R12 still full", destFull, 1);
    for (int i = 0; i < 8; i++) begin
      retire(2'd1, 3'd0, 32'h1000 + 32'(i), 32'h0);
      model[16 + i] = 32'h1000 + 32'(i);
    end
    check("R12 drained", destEmpty, 1);
    checkRegs("R12 overflow ignored");
  endtask

  task automatic t_flags();
    push(6'd3);
    retire(2'd1, 3'd0, 32'h8000_00A5, 32'h0);
    model[3] = 32'h8000_00A5;
    for (int i = 0; i < 32; i++) begin
      condSel = 5'(i);
      #1;
      check("R11 flag bit", 32'(condFlag), 32'(model[3][i]));
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_store();
    t_bigidx();
    t_empty();
    t_nottaken();
    t_taken();
    t_flushpush();
    t_full();
    t_flags();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule